// File: doc/BRIEF.md
# TDM Slot Window Gate

This block opens a gate for a serial transmitter or receiver during one contiguous run of time slots inside a time-division multiplexed frame, as used on ISDN, T1 and fractional E1 links. A frame sync pulse marks the start of each frame. The block counts bit periods and 8-bit slots from that reference and raises its gate while the slot count lies inside the programmed run. The gate can drive the enable of an external line driver. A second output gives the serial shifter a one-clock enable for each bit inside the window.

The block runs on a fast core clock. `bit_en` is a one-clock strobe that marks each bit clock, and the block samples `fsync` only on those strobes. Three inputs set the window: the first slot (0 to 127), the number of slots (1 to 15) and an offset of 0 to 7 bit clocks. The offset makes up for the latency of sync detection. The block captures all three values when it accepts a sync, so a change on these inputs during a frame has no effect until the next sync. Transmit and receive each use their own instance.

Top module: `slot_window_gate`

## Requirements
- R1: After reset, `gate` and `shift_en` are low. `gate` stays low, even with `bit_en` strobes, until a sync has been accepted.
- R2: A sync is accepted only in a clock where `bit_en` and `fsync` are both high. `fsync` has no effect while `bit_en` is low.
- R3: Number the `bit_en` strobes after the sync strobe from k = 1, and let n = k − 1 − offset. After strobe k, `gate` is high exactly when 8·first ≤ n < 8·(first+count). Each slot is 8 bit clocks, so the window lasts 8·count strobes.
- R4: The first slot can be any value from 0 to 127, including both end points.
- R5: The slot count can be 1 to 15. A count of 0 gives a window that never opens.
- R6: The offset can be 0 to 7. It delays bit 0 of slot 0 by that many bit clocks.
- R7: `first_slot`, `slot_count` and `sync_offset` are captured on the accepted sync strobe. Changes on them during a frame do not alter that frame's window.
- R8: If no new sync arrives, the slot count saturates at the end of the window. `gate` then stays low for any number of further strobes.
- R9: A sync strobe arriving while the window is open closes `gate` after that strobe and starts a new frame.
- R10: `shift_en` is high only in a clock where `bit_en` is high and `gate` is high, and it is high in every such clock.
- R11: `gate` changes only on a clock edge at which `bit_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-clock strobe per serial bit clock |
| fsync | input | 1 | Frame sync, sampled on `bit_en` strobes |
| first_slot | input | 7 | Index of the first slot in the window |
| slot_count | input | 4 | Number of consecutive slots in the window |
| sync_offset | input | 3 | Delay in bit clocks from sync to bit 0 of slot 0 |
| gate | output | 1 | High while the current bit lies inside the window |
| shift_en | output | 1 | Per-bit enable for the serial shifter |

## Verification
A wrong bit counter or delay counter moves the gate edges by a few bit clocks. This shows within the first window after a sync, at its rising edge and again at its falling edge. A wrong slot counter, or a lost saturation, shows either as a window of the wrong length or as the gate opening again long after the window. A counter that wraps instead of saturating reopens the gate only after 256 slots, so the bench runs one frame for more than 2000 bit clocks with no sync. A shadow register that is not held shows as soon as the configuration inputs change in the middle of a frame.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int unsigned TSA_SLOT_W        = 7;
  localparam int unsigned TSA_NUM_W         = 4;
  localparam int unsigned TSA_OFS_W         = 3;
  localparam int unsigned TSA_BITS_PER_SLOT = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_COUNT = 2'd2
  } tsa_phase_e;
endpackage

// File: rtl/tsa_cfg_shadow.sv
module tsa_cfg_shadow #(
  parameter int unsigned SLOT_W = 7,
  parameter int unsigned NUM_W  = 4,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SLOT_W-1:0] first_in,
  input  logic [NUM_W-1:0]  num_in,
  output logic [CNT_W-1:0]  first_q,
  output logic [CNT_W-1:0]  limit_q
);
  logic [CNT_W-1:0] first_d;
  logic [CNT_W-1:0] limit_d;

  always_comb begin
    first_d = first_q;
    limit_d = limit_q;
    if (load) begin
      first_d = CNT_W'(first_in);
      limit_d = CNT_W'(first_in) + CNT_W'(num_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      limit_q <= '0;
    end else if (load) begin
      first_q <= first_d;
      limit_q <= limit_d;
    end
  end
endmodule

// File: rtl/tsa_phase_ctl.sv
module tsa_phase_ctl
  import tsa_pkg::*;
#(
  parameter int unsigned OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sync,
  input  logic [OFS_W-1:0] ofs,
  output logic             start,
  output logic             keep_on
);
  tsa_phase_e       phase_q, phase_d;
  logic [OFS_W-1:0] dly_q, dly_d;
  logic             sync_tick;

  assign sync_tick = tick && sync;

  always_comb begin
    phase_d = phase_q;
    dly_d   = dly_q;
    start   = 1'b0;
    if (sync_tick) begin
      phase_d = PH_DELAY;
      dly_d   = ofs;
    end else if (tick && phase_q == PH_DELAY) begin
      if (dly_q == '0) begin
        phase_d = PH_COUNT;
        start   = 1'b1;
      end else begin
        dly_d = dly_q - OFS_W'(1);
      end
    end
  end

  assign keep_on = (phase_q == PH_COUNT) && !sync_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      dly_q   <= '0;
    end else if (tick) begin
      phase_q <= phase_d;
      dly_q   <= dly_d;
    end
  end
endmodule

// File: rtl/tsa_slot_counter.sv
module tsa_slot_counter #(
  parameter int unsigned BITS_PER_SLOT = 8,
  parameter int unsigned CNT_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             keep_on,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] slot_d
);
  localparam int unsigned BIT_W = (BITS_PER_SLOT > 1) ? $clog2(BITS_PER_SLOT) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_SLOT - 1);

  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CNT_W-1:0] slot_q;

  always_comb begin
    bit_d  = bit_q;
    slot_d = slot_q;
    if (tick) begin
      if (start) begin
        bit_d  = '0;
        slot_d = '0;
      end else if (keep_on) begin
        if (bit_q == BIT_LAST) begin
          bit_d = '0;
          if (slot_q != limit) begin
            slot_d = slot_q + CNT_W'(1);
          end
        end else begin
          bit_d = bit_q + BIT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else if (tick) begin
      bit_q  <= bit_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/tsa_window_cmp.sv
module tsa_window_cmp #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active_nxt,
  input  logic [CNT_W-1:0] slot_nxt,
  input  logic [CNT_W-1:0] first,
  input  logic [CNT_W-1:0] limit,
  output logic             gate_q
);
  logic gate_d;

  always_comb begin
    gate_d = active_nxt && (slot_nxt >= first) && (slot_nxt < limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else if (tick) begin
      gate_q <= gate_d;
    end
  end
endmodule

// File: rtl/slot_window_gate.sv
module slot_window_gate
  import tsa_pkg::*;
#(
  parameter int unsigned SLOT_W        = TSA_SLOT_W,
  parameter int unsigned NUM_W         = TSA_NUM_W,
  parameter int unsigned OFS_W         = TSA_OFS_W,
  parameter int unsigned BITS_PER_SLOT = TSA_BITS_PER_SLOT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              fsync,
  input  logic [SLOT_W-1:0] first_slot,
  input  logic [NUM_W-1:0]  slot_count,
  input  logic [OFS_W-1:0]  sync_offset,
  output logic              gate,
  output logic              shift_en
);
  localparam int unsigned CNT_W = $clog2((1 << SLOT_W) + (1 << NUM_W));

  logic             sync_load;
  logic             start;
  logic             keep_on;
  logic             active_nxt;
  logic [CNT_W-1:0] first_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] slot_nxt;

  assign sync_load  = bit_en && fsync;
  assign active_nxt = start || keep_on;

  tsa_cfg_shadow #(
    .SLOT_W (SLOT_W),
    .NUM_W  (NUM_W),
    .CNT_W  (CNT_W)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sync_load),
    .first_in (first_slot),
    .num_in   (slot_count),
    .first_q  (first_q),
    .limit_q  (limit_q)
  );

  tsa_phase_ctl #(
    .OFS_W (OFS_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (bit_en),
    .sync    (fsync),
    .ofs     (sync_offset),
    .start   (start),
    .keep_on (keep_on)
  );

  tsa_slot_counter #(
    .BITS_PER_SLOT (BITS_PER_SLOT),
    .CNT_W         (CNT_W)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (bit_en),
    .start   (start),
    .keep_on (keep_on),
    .limit   (limit_q),
    .slot_d  (slot_nxt)
  );

  tsa_window_cmp #(
    .CNT_W (CNT_W)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (bit_en),
    .active_nxt (active_nxt),
    .slot_nxt   (slot_nxt),
    .first      (first_q),
    .limit      (limit_q),
    .gate_q     (gate)
  );

  assign shift_en = gate && bit_en;
endmodule

// File: rtl/tsa_gate_checker.sv
module tsa_gate_checker #(
  parameter int unsigned NUM_W         = 4,
  parameter int unsigned BITS_PER_SLOT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic fsync,
  input logic gate,
  input logic shift_en
);
  localparam int unsigned MAX_RUN = BITS_PER_SLOT * ((1 << NUM_W) - 1);
  localparam int unsigned RUN_W   = $clog2(MAX_RUN + 2);

  logic             past_ok;
  logic             seen_sync;
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok   <= 1'b0;
      seen_sync <= 1'b0;
      run_cnt   <= '0;
    end else begin
      past_ok <= 1'b1;
      if (bit_en && fsync) seen_sync <= 1'b1;
      if (!gate) run_cnt <= '0;
      else if (bit_en && run_cnt <= RUN_W'(MAX_RUN)) run_cnt <= run_cnt + RUN_W'(1);
    end
  end

  assert_no_gate_before_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_sync |-> !gate);

  assert_window_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_W'(MAX_RUN));

  assert_resync_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bit_en && fsync)) |-> !gate);

  assert_shift_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (bit_en && gate));

  assert_shift_every_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && gate) |-> shift_en);

  assert_gate_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(bit_en)) |-> $stable(gate));
endmodule

bind slot_window_gate tsa_gate_checker #(
  .NUM_W         (NUM_W),
  .BITS_PER_SLOT (BITS_PER_SLOT)
) u_gate_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_en   (bit_en),
  .fsync    (fsync),
  .gate     (gate),
  .shift_en (shift_en)
);

// File: tb/slot_window_gate_bench.sv
module slot_window_gate_bench;
  logic       clk;
  logic       rst_n;
  logic       bit_en;
  logic       fsync;
  logic [6:0] first_slot;
  logic [3:0] slot_count;
  logic [2:0] sync_offset;
  logic       gate;
  logic       shift_en;

  int n_checks;
  int n_fail;
  bit finished;

  // model state
  bit seen;
  int k, mf, mn, md;
  bit exp_gate;

  // vectors: {first[6:0], count[3:0], offset[2:0]}
  localparam logic [13:0] VEC [8] = '{
    {7'd0,   4'd1,  3'd0},
    {7'd1,   4'd2,  3'd0},
    {7'd2,   4'd3,  3'd7},
    {7'd0,   4'd15, 3'd3},
    {7'd5,   4'd4,  3'd1},
    {7'd10,  4'd1,  3'd5},
    {7'd3,   4'd7,  3'd2},
    {7'd127, 4'd15, 3'd4}
  };

  slot_window_gate u_slot_window_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .fsync       (fsync),
    .first_slot  (first_slot),
    .slot_count  (slot_count),
    .sync_offset (sync_offset),
    .gate        (gate),
    .shift_en    (shift_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic bit model_gate();
    int n;
    if (!seen) return 1'b0;
    n = k - 1 - md;
    return (n >= 0) && (n >= 8 * mf) && (n < 8 * (mf + mn));
  endfunction

  // one bit strobe; called just after a falling edge
  task automatic tick(input logic sync, input string tag);
    bit_en = 1'b1;
    fsync  = sync;
    #1;
    check("R10 shift_en in strobe", shift_en, exp_gate);
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0;
    fsync  = 1'b0;
    if (sync) begin
      seen = 1'b1; k = 0;
      mf = first_slot; mn = slot_count; md = sync_offset;
    end else if (seen) begin
      k++;
    end
    exp_gate = model_gate();
    check(tag, gate, exp_gate);
    @(posedge clk);
    @(negedge clk);
    check("R11 gate held between strobes", gate, exp_gate);
    check("R10 shift_en idle", shift_en, 1'b0);
  endtask

  task automatic set_cfg(input int f, input int m, input int d);
    first_slot  = 7'(f);
    slot_count  = 4'(m);
    sync_offset = 3'(d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bit_en = 1'b0;
    fsync = 1'b0;
    seen = 1'b0; k = 0; exp_gate = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fail = 0;
    finished = 0;
    set_cfg(0, 1, 0);
    do_reset();

    // R1: reset state, strobes without sync leave gate low
    check("R1 gate after reset", gate, 1'b0);
    check("R1 shift_en after reset", shift_en, 1'b0);
    repeat (20) tick(1'b0, "R1 no sync yet");

    // R2: fsync without strobe is ignored
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    repeat (12) tick(1'b0, "R2 fsync without bit_en");

    // table walk: R3, R4, R6 over several windows
    foreach (VEC[i]) begin
      int f, m, d;
      f = VEC[i][13:7];
      m = VEC[i][6:3];
      d = VEC[i][2:0];
      set_cfg(f, m, d);
      tick(1'b1, "R3 sync strobe");
      repeat (8 * (f + m) + d + 10) tick(1'b0, "R3 R4 R6 window");
    end

    // R5: zero count never opens
    set_cfg(2, 0, 0);
    tick(1'b1, "R5 sync");
    repeat (60) tick(1'b0, "R5 zero count");

    // R7: config change mid-frame ignored
    set_cfg(2, 2, 1);
    tick(1'b1, "R7 sync");
    repeat (5) tick(1'b0, "R7 before change");
    set_cfg(0, 9, 6);
    repeat (50) tick(1'b0, "R7 captured config holds");

    // R8: long run without sync, no reopen after counter range
    set_cfg(0, 1, 0);
    tick(1'b1, "R8 sync");
    repeat (2200) tick(1'b0, "R8 saturation");

    // R9: resync inside an open window
    set_cfg(1, 3, 0);
    tick(1'b1, "R9 sync");
    repeat (14) tick(1'b0, "R9 open window");
    check("R9 window open before resync", gate, 1'b1);
    set_cfg(4, 1, 2);
    tick(1'b1, "R9 resync closes gate");
    repeat (50) tick(1'b0, "R9 new frame");

    // R1: reset during an open window
    set_cfg(0, 2, 0);
    tick(1'b1, "R1 sync");
    repeat (4) tick(1'b0, "R1 window");
    check("R1 gate open before reset", gate, 1'b1);
    do_reset();
    check("R1 gate cleared by reset", gate, 1'b0);
    repeat (10) tick(1'b0, "R1 no sync after reset");

    finished = 1;
    summary();
    $finish;
  end
endmodule